// File: doc/BRIEF.md
# SPI Host Interrupt Aggregator

This block gathers the error and event conditions of an SPI host controller and turns them into two interrupt lines: one for errors, one for events. The datapath reports errors as one-cycle pulses, which are caught in a sticky error-status register. It reports events as level conditions, for example the RX queue being full or the controller being ready. Each class has its own cause mask. A qualifying cause sets a sticky interrupt-state bit. Software clears that bit by writing 1 to it.

Software reaches the block through a small single-cycle register port. Writes take effect on the next clock edge, and reads are combinational from the address. An interrupt-enable register gates both the setting of the state bits and the outputs. A write-only test register lets software inject either interrupt without a real cause.

Register addresses: 0 interrupt state (bit 0 error, bit 1 event, write 1 to clear), 1 interrupt enable (same bits), 2 interrupt test (same bits, write-only), 3 error mask, 4 error status (write 1 to clear), 5 event mask.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset the error mask reads 0x1F. Interrupt state, interrupt enable, error status and event mask read 0. Both interrupt outputs are low.
- R2: The enable registers (address 1, bits 1:0; address 3, bits 5:0; address 5, bits 5:0) read back what was written. The test register (address 2) and unmapped addresses read 0.
- R3: A pulse on err_pulse bit i sets error-status bit i at the next edge. The bit then stays set with no further pulses. Bit meanings: 0 command while busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip-select ID, 5 invalid access.
- R4: Writing to error status (address 4) clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R5: An error pulse that arrives in the same cycle as a write-1-to-clear of the same bit leaves that bit set.
- R6: When interrupt-enable bit 0 is set and any error-status bit is set whose error-mask bit is also set, interrupt-state bit 0 is set at the next edge.
- R7: When interrupt-enable bit 1 is set and any event-mask bit is set whose evt_level bit is high, interrupt-state bit 1 is set at the next edge. Event bits: 0 RX full, 1 TX empty, 2 RX watermark, 3 TX watermark, 4 ready, 5 idle.
- R8: irq_err equals interrupt-state bit 0 AND enable bit 0. irq_evt equals state bit 1 AND enable bit 1. Clearing an enable bit drops the output but keeps the state bit.
- R9: Interrupt-state bits are sticky and are cleared only by writing 1 to address 0. If a cause is still present in the same cycle, the set wins and the bit stays set.
- R10: Writing 1 to a test-register bit sets the matching state bit only when that interrupt is enabled.
- R11: An error whose mask bit is 0 is still recorded in error status but raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr (combinational) |
| err_pulse | input | N_ERR (6) | One-cycle error pulses from the datapath |
| evt_level | input | N_EVT (6) | Level event conditions from the datapath |
| irq_err | output | 1 | Error interrupt |
| irq_evt | output | 1 | Event interrupt |

## Verification
The assertions assume that inputs change only away from the rising edge. They also assume that a register write lasts exactly one cycle, so a clear of error status can always be traced to a write to address 4 in the cycle before. The bench drives every input two time units after the edge, holds each write strobe for a single cycle, and pulses err_pulse for one cycle. It deliberately lines up a pulse with a clear of the same bit to exercise the set-over-clear ordering.

// File: rtl/spi_irq_agg.sv
module spi_irq_agg #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int N_ERR  = 6,
  parameter int N_EVT  = 6,
  parameter logic [N_ERR-1:0] ERR_EN_RST = {N_ERR{1'b1}} >> 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_ERR-1:0]  err_pulse,
  input  logic [N_EVT-1:0]  evt_level,
  output logic              irq_err,
  output logic              irq_evt
);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ITEST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ERREN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ERRST = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_EVTEN = ADDR_W'(5);

  logic [1:0]       int_state, int_en;
  logic [N_ERR-1:0] err_st, err_en;
  logic [N_EVT-1:0] evt_en;

  logic wr_state, wr_ien, wr_itest, wr_erren, wr_errst, wr_evten;
  assign wr_state = reg_we && reg_addr == A_STATE;
  assign wr_ien   = reg_we && reg_addr == A_IEN;
  assign wr_itest = reg_we && reg_addr == A_ITEST;
  assign wr_erren = reg_we && reg_addr == A_ERREN;
  assign wr_errst = reg_we && reg_addr == A_ERRST;
  assign wr_evten = reg_we && reg_addr == A_EVTEN;

  logic       err_cause, evt_cause;
  logic [1:0] test_set, state_clr, state_set;
  logic [N_ERR-1:0] err_clr;

  assign err_cause = |(err_st & err_en);
  assign evt_cause = |(evt_en & evt_level);
  assign test_set  = wr_itest ? reg_wdata[1:0] : 2'b00;
  assign state_clr = wr_state ? reg_wdata[1:0] : 2'b00;
  assign state_set = int_en & ({evt_cause, err_cause} | test_set);
  assign err_clr   = wr_errst ? reg_wdata[N_ERR-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_state <= '0;
      int_en    <= '0;
      err_st    <= '0;
      err_en    <= ERR_EN_RST;
      evt_en    <= '0;
    end else begin
      int_state <= (int_state & ~state_clr) | state_set;
      err_st    <= (err_st & ~err_clr) | err_pulse;
      if (wr_ien)   int_en <= reg_wdata[1:0];
      if (wr_erren) err_en <= reg_wdata[N_ERR-1:0];
      if (wr_evten) evt_en <= reg_wdata[N_EVT-1:0];
    end
  end

  assign irq_err = int_state[0] & int_en[0];
  assign irq_evt = int_state[1] & int_en[1];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATE: reg_rdata[1:0]       = int_state;
      A_IEN:   reg_rdata[1:0]       = int_en;
      A_ERREN: reg_rdata[N_ERR-1:0] = err_en;
      A_ERRST: reg_rdata[N_ERR-1:0] = err_st;
      A_EVTEN: reg_rdata[N_EVT-1:0] = evt_en;
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/spi_irq_agg_chk.sv
module spi_irq_agg_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int N_ERR  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [N_ERR-1:0]  err_pulse,
  input logic [N_ERR-1:0]  err_st,
  input logic [1:0]        int_state,
  input logic [1:0]        int_en,
  input logic              irq_err,
  input logic              irq_evt
);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ERRST = ADDR_W'(4);

  assert_pulse_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((err_st & $past(err_pulse)) == $past(err_pulse)));

  assert_status_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err_st) & ~err_st)) |->
      ($past(reg_we) && $past(reg_addr) == A_ERRST &&
       (($past(err_st) & ~err_st & ~$past(reg_wdata[N_ERR-1:0])) == '0)));

  assert_irq_err_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> int_en[0]);

  assert_irq_evt_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |-> int_en[1]);

  assert_err_state_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_state[0] && !(reg_we && reg_addr == A_STATE && reg_wdata[0])) |=> int_state[0]);

  assert_evt_state_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_state[1]) |-> $past(int_en[1]));
endmodule

bind spi_irq_agg spi_irq_agg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_ERR(N_ERR)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .err_pulse(err_pulse), .err_st(err_st), .int_state(int_state), .int_en(int_en),
  .irq_err(irq_err), .irq_evt(irq_evt)
);

// File: tb/spi_irq_agg_tb_top.sv
module spi_irq_agg_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  err_pulse = '0;
  logic [5:0]  evt_level = '0;
  logic        irq_err, irq_evt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_pulse(err_pulse),
    .evt_level(evt_level), .irq_err(irq_err), .irq_evt(irq_evt)
  );

  // reference model
  bit [1:0] m_ist, m_ien;
  bit [5:0] m_errst, m_erren, m_evten;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ist <= 0; m_ien <= 0; m_errst <= 0; m_erren <= 6'h1F; m_evten <= 0;
    end else begin
      bit [1:0] nst;
      bit [5:0] nerr;
      bit ecause, vcause;
      ecause = 0; vcause = 0;
      for (int i = 0; i < 6; i++) begin
        if (m_errst[i] && m_erren[i]) ecause = 1;
        if (m_evten[i] && evt_level[i]) vcause = 1;
      end
      nst = m_ist;
      nerr = m_errst;
      if (reg_we && reg_addr == 0) nst = nst & ~reg_wdata[1:0];
      if (m_ien[0] && (ecause || (reg_we && reg_addr == 2 && reg_wdata[0]))) nst[0] = 1;
      if (m_ien[1] && (vcause || (reg_we && reg_addr == 2 && reg_wdata[1]))) nst[1] = 1;
      if (reg_we && reg_addr == 4) nerr = nerr & ~reg_wdata[5:0];
      nerr = nerr | err_pulse;
      m_ist <= nst;
      m_errst <= nerr;
      if (reg_we && reg_addr == 1) m_ien <= reg_wdata[1:0];
      if (reg_we && reg_addr == 3) m_erren <= reg_wdata[5:0];
      if (reg_we && reg_addr == 5) m_evten <= reg_wdata[5:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, m_ist};
      3'd1: return {30'd0, m_ien};
      3'd3: return {26'd0, m_erren};
      3'd4: return {26'd0, m_errst};
      3'd5: return {26'd0, m_evten};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // outputs compared against the model every cycle (R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 irq_err", {31'd0, irq_err}, {31'd0, m_ist[0] & m_ien[0]});
      check("R8 irq_evt", {31'd0, irq_evt}, {31'd0, m_ist[1] & m_ien[1]});
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [5:0] e);
    err_pulse = e;
    step();
    err_pulse = '0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
    check({tag, " model"}, reg_rdata, m_read(a));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset values
    rd("R1 state", 0, 0); rd("R1 ien", 1, 0); rd("R1 erren", 3, 32'h1F);
    rd("R1 errst", 4, 0); rd("R1 evten", 5, 0);
    check("R1 irqs", {30'd0, irq_evt, irq_err}, 0);
    // R2 readback
    wr(1, 32'hFFFF_FFFF); rd("R2 ien", 1, 3);
    wr(1, 0);
    wr(3, 32'h3F); rd("R2 erren", 3, 32'h3F);
    wr(5, 32'h2A); rd("R2 evten", 5, 32'h2A);
    wr(2, 0); rd("R2 test reads zero", 2, 0);
    rd("R2 unmapped", 7, 0);
    wr(3, 32'h1F); wr(5, 0);
    // R3 sticky capture
    pulse(6'h04); rd("R3 capture", 4, 32'h04);
    repeat (4) step(); rd("R3 sticky", 4, 32'h04);
    // R4 write one to clear
    wr(4, 0); rd("R4 zero keeps", 4, 32'h04);
    pulse(6'h09); wr(4, 32'h04); rd("R4 partial clear", 4, 32'h09);
    wr(4, 32'h3F); rd("R4 all clear", 4, 0);
    // R5 pulse wins over clear
    pulse(6'h02);
    err_pulse = 6'h02; reg_we = 1; reg_addr = 4; reg_wdata = 32'h02;
    step();
    err_pulse = 0; reg_we = 0; reg_wdata = 0;
    rd("R5 set over clear", 4, 32'h02);
    wr(4, 32'h3F);
    // R6 error interrupt
    wr(1, 1);
    pulse(6'h01); step();
    rd("R6 state set", 0, 1);
    check("R6 irq_err", {31'd0, irq_err}, 1);
    // R9 clear with cause present: set wins
    wr(0, 1); rd("R9 reset by live cause", 0, 1);
    wr(4, 32'h3F); wr(0, 1); rd("R9 cleared", 0, 0);
    check("R9 irq_err low", {31'd0, irq_err}, 0);
    // R11 masked error
    pulse(6'h20); step(); step();
    rd("R11 recorded", 4, 32'h20); rd("R11 no state", 0, 0);
    check("R11 irq_err low", {31'd0, irq_err}, 0);
    wr(4, 32'h3F);
    // R7 event interrupt
    wr(1, 2); wr(5, 32'h10); evt_level = 6'h10; step();
    rd("R7 event state", 0, 2);
    check("R7 irq_evt", {31'd0, irq_evt}, 1);
    // R8 masking keeps state
    wr(1, 0); rd("R8 state kept", 0, 2);
    check("R8 irq_evt masked", {31'd0, irq_evt}, 0);
    evt_level = 6'h10; wr(5, 32'h01); wr(0, 3);
    wr(1, 2); step(); rd("R7 unmasked event ignored", 0, 0);
    evt_level = 0; wr(5, 0);
    // R10 test injection
    wr(1, 0); wr(2, 3); rd("R10 disabled test", 0, 0);
    wr(1, 3); wr(2, 1); rd("R10 error test", 0, 1);
    wr(2, 2); rd("R10 event test", 0, 3);
    check("R10 both irqs", {30'd0, irq_evt, irq_err}, 3);
    wr(0, 3); rd("R9 test cleared", 0, 0);
    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule